// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter with Overflow Toggle

This block holds two timer/counter channels that share a machine-cycle tick. A channel advances either once per tick (timer function) or once per falling edge seen on its count input (counter function). The count input is sampled once per tick. Each channel can run as a 13-bit prescaled counter, a 16-bit counter, an 8-bit counter that reloads itself, or an 8-bit pulse-width modulator with a 256-count period. Timer 0 can also split into two independent 8-bit counters, and while it does so timer 1 loses its overflow flag and toggle to the upper half of timer 0.

Software loads the count bytes through one byte-wide write port and reads all four bytes back directly. Each channel has a sticky overflow flag that software clears. Each channel also has a toggle output that flips on every overflow, and a PWM output that is active only in the PWM mode.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every count byte reads 0, both overflow flags are 0, both toggle outputs are 1 and both PWM outputs are 0.
- R2: A channel counts only in a cycle where tick_i is 1, its run bit is 1, and either its gate bit is 0 or its gate pin is 1. When tick_i is 0 and no write occurs, no count byte changes.
- R3: With cnt_sel_i set for a channel, the count input is sampled on each tick. The channel advances by one when the previous sample was 1 and the current sample is 0. It ignores the tick otherwise.
- R4: Mode code 0 forms a 13-bit count. Its low 5 bits are the low 5 bits of the low byte and its upper 8 bits are the high byte. Low-byte bits 7..5 are left unchanged. Stepping from all ones wraps the count to zero and is an overflow.
- R5: Mode code 1 forms a 16-bit count from the high and low bytes. Stepping from 16'hFFFF wraps to zero and is an overflow.
- R6: Mode code 2 steps only the low byte. Stepping from 8'hFF loads the low byte with the high byte and is an overflow.
- R7: Mode code 3 on timer 0 gives two 8-bit counters. The low byte follows timer 0's controls and drives flag 0. The high byte counts ticks whenever run_i[1] is 1 and drives flag 1 and toggle 1. In this state, timer 1's own overflows reach neither flag 1 nor toggle 1. Mode code 3 on timer 1 stops timer 1.
- R8: Mode code 6 steps the low byte freely, with an overflow on every wrap from 8'hFF. The PWM output is 1 exactly while the low byte is below the high byte. In any other mode the PWM output is 0, and codes 4, 5 and 7 hold the count.
- R9: An overflow sets the channel flag. ovf_clr_i clears the flag, and a set arriving in the same cycle as a clear wins.
- R10: While toggle is disabled, the toggle output is held at 1. While toggle is enabled, the output inverts on every overflow event of that channel.
- R11: A write with wr_sel_i = 0, 1, 2 or 3 loads the timer 0 low byte, timer 0 high byte, timer 1 low byte or timer 1 high byte. The write overrides the count for that byte in the same cycle, and the other byte still takes its counted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle enable |
| run_i | input | 2 | Run bit per channel |
| gate_i | input | 2 | Gate enable per channel |
| gate_pin_i | input | 2 | Gate pin per channel |
| cnt_sel_i | input | 2 | 1 selects counter function |
| cnt_pin_i | input | 2 | External count input |
| mode_i | input | 6 | Mode code, timer 0 in [2:0], timer 1 in [5:3] |
| tog_en_i | input | 2 | Overflow toggle enable |
| wr_en_i | input | 1 | Byte write strobe |
| wr_sel_i | input | 2 | Byte select for writes |
| wr_data_i | input | 8 | Write data |
| ovf_clr_i | input | 2 | Overflow flag clear |
| tl0_o | output | 8 | Timer 0 low byte |
| th0_o | output | 8 | Timer 0 high byte |
| tl1_o | output | 8 | Timer 1 low byte |
| th1_o | output | 8 | Timer 1 high byte |
| ovf_o | output | 2 | Overflow flags |
| tog_o | output | 2 | Toggle outputs |
| pwm_o | output | 2 | PWM outputs |

## Verification
The bench targets the wrap points of each mode.
- Mode 0 must carry out of the 5-bit prescaler into the high byte without touching low-byte bits 7..5. A design that carried from bit 7 would count 8 times too slowly.
- Mode 2 must reload from the high byte rather than wrap to zero.
- The split mode must move flag 1 and toggle 1 over to the upper half of timer 0. A design that missed this would raise timer 1's flag from its own overflows.

Directed cases also cover these points:
- A held-low count input must give one count, not one per tick.
- A closed gate must block counting.
- A write in the same cycle as a count must keep the written byte.
- Toggle must read 1 until the first overflow after it is enabled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    M_PRE13 = 3'd0,
    M_FULL  = 3'd1,
    M_RLD8  = 3'd2,
    M_SPLIT = 3'd3,
    M_PWM   = 3'd6
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b0;
    else if (tick_i) prev_q <= pin_i;
  end

  assign fall_o = tick_i & prev_q & ~pin_i;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int BW = 8,
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          inc_i,
  input  logic          inc_hi_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] tl_o,
  output logic [BW-1:0] th_o,
  output logic          ovf_o,
  output logic          ovf_hi_o,
  output logic          pwm_o
);
  import tmr_pkg::*;

  localparam logic [BW-1:0]   BMAX = '1;
  localparam logic [BW-1:0]   BONE = BW'(1);
  localparam logic [PW-1:0]   PMAX = '1;
  localparam logic [PW-1:0]   PONE = PW'(1);
  localparam logic [2*BW-1:0] WONE = (2*BW)'(1);

  logic [BW-1:0] tl_q, th_q, tl_n, th_n;

  always_comb begin
    tl_n     = tl_q;
    th_n     = th_q;
    ovf_o    = 1'b0;
    ovf_hi_o = 1'b0;
    case (mode_i)
      M_PRE13: if (inc_i) begin
        if (tl_q[PW-1:0] == PMAX) begin
          tl_n[PW-1:0] = '0;
          th_n         = th_q + BONE;
          ovf_o        = (th_q == BMAX);
        end else begin
          tl_n[PW-1:0] = tl_q[PW-1:0] + PONE;
        end
      end
      M_FULL: if (inc_i) begin
        {th_n, tl_n} = {th_q, tl_q} + WONE;
        ovf_o        = &{th_q, tl_q};
      end
      M_RLD8: if (inc_i) begin
        tl_n  = (tl_q == BMAX) ? th_q : tl_q + BONE;
        ovf_o = (tl_q == BMAX);
      end
      M_SPLIT: begin
        if (inc_i) begin
          tl_n  = tl_q + BONE;
          ovf_o = (tl_q == BMAX);
        end
        if (inc_hi_i) begin
          th_n     = th_q + BONE;
          ovf_hi_o = (th_q == BMAX);
        end
      end
      M_PWM: if (inc_i) begin
        tl_n  = tl_q + BONE;
        ovf_o = (tl_q == BMAX);
      end
      default: ;
    endcase
    if (wr_lo_i) tl_n = wdata_i;
    if (wr_hi_i) th_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tl_q <= '0;
      th_q <= '0;
    end else begin
      tl_q <= tl_n;
      th_q <= th_n;
    end
  end

  assign tl_o  = tl_q;
  assign th_o  = th_q;
  assign pwm_o = (mode_i == M_PWM) && (tl_q < th_q);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int BW = 8,
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [1:0]    run_i,
  input  logic [1:0]    gate_i,
  input  logic [1:0]    gate_pin_i,
  input  logic [1:0]    cnt_sel_i,
  input  logic [1:0]    cnt_pin_i,
  input  logic [5:0]    mode_i,
  input  logic [1:0]    tog_en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [BW-1:0] wr_data_i,
  input  logic [1:0]    ovf_clr_i,
  output logic [BW-1:0] tl0_o,
  output logic [BW-1:0] th0_o,
  output logic [BW-1:0] tl1_o,
  output logic [BW-1:0] th1_o,
  output logic [1:0]    ovf_o,
  output logic [1:0]    tog_o,
  output logic [1:0]    pwm_o
);
  import tmr_pkg::*;

  localparam int NT = 2;

  logic [BW-1:0] tl_w [NT];
  logic [BW-1:0] th_w [NT];
  logic [NT-1:0] ovf_w, ovf_hi_w, evt_w;
  logic [NT-1:0] ovf_q, tog_q;

  for (genvar i = 0; i < NT; i++) begin : g_ch
    logic [2:0] md;
    logic       fall, open, halt, inc, inc_hi;

    assign md = mode_i[3*i +: 3];

    tmr_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .pin_i  (cnt_pin_i[i]),
      .fall_o (fall)
    );

    assign open   = run_i[i] & (~gate_i[i] | gate_pin_i[i]);
    // timer 1 stops in split code
    assign halt   = (i == 1) && (md == M_SPLIT);
    assign inc    = open & ~halt & (cnt_sel_i[i] ? fall : tick_i);
    // upper half of timer 0 borrows timer 1's run bit
    assign inc_hi = (i == 0) ? (tick_i & run_i[NT-1]) : 1'b0;

    tmr_core #(.BW(BW), .PW(PW)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (md),
      .inc_i    (inc),
      .inc_hi_i (inc_hi),
      .wr_lo_i  (wr_en_i && (wr_sel_i == 2'(2*i))),
      .wr_hi_i  (wr_en_i && (wr_sel_i == 2'(2*i+1))),
      .wdata_i  (wr_data_i),
      .tl_o     (tl_w[i]),
      .th_o     (th_w[i]),
      .ovf_o    (ovf_w[i]),
      .ovf_hi_o (ovf_hi_w[i]),
      .pwm_o    (pwm_o[i])
    );
  end

  assign evt_w[0] = ovf_w[0];
  assign evt_w[1] = (mode_i[2:0] == M_SPLIT) ? ovf_hi_w[0] : ovf_w[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= '0;
      tog_q <= '1;
    end else begin
      for (int k = 0; k < NT; k++) begin
        if (evt_w[k])          ovf_q[k] <= 1'b1;
        else if (ovf_clr_i[k]) ovf_q[k] <= 1'b0;
        if (!tog_en_i[k])      tog_q[k] <= 1'b1;
        else if (evt_w[k])     tog_q[k] <= ~tog_q[k];
      end
    end
  end

  assign tl0_o = tl_w[0];
  assign th0_o = th_w[0];
  assign tl1_o = tl_w[1];
  assign th1_o = th_w[1];
  assign ovf_o = ovf_q;
  assign tog_o = tog_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int BW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic [5:0]    mode_i,
  input logic [1:0]    tog_en_i,
  input logic          wr_en_i,
  input logic [1:0]    ovf_clr_i,
  input logic [BW-1:0] tl0_o,
  input logic [BW-1:0] th0_o,
  input logic [BW-1:0] tl1_o,
  input logic [BW-1:0] th1_o,
  input logic [1:0]    ovf_o,
  input logic [1:0]    tog_o,
  input logic [1:0]    pwm_o
);
  // R2
  tick_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_en_i |=> $stable({tl0_o, th0_o, tl1_o, th1_o}));

  // R7
  t1_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[5:3] == 3'd3) && !wr_en_i |=> $stable({tl1_o, th1_o}));

  // R8
  pwm_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:0] == 3'd6) && (th0_o == '0) |-> !pwm_o[0]);

  // R8
  pwm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[5:3] != 3'd6) |-> !pwm_o[1]);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o[0] && !ovf_clr_i[0] |=> ovf_o[0]);

  // R10
  tog_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tog_en_i[1] |=> tog_o[1]);
endmodule

bind tmr_pair tmr_pair_chk #(.BW(BW)) u_chk (.*);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] run_i = '0, gate_i = '0, gate_pin_i = '0, cnt_sel_i = '0, cnt_pin_i = '0;
  logic [5:0] mode_i = '0;
  logic [1:0] tog_en_i = '0, wr_sel_i = '0, ovf_clr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] tl0_o, th0_o, tl1_o, th1_o;
  logic [1:0] ovf_o, tog_o, pwm_o;

  int errs = 0, checks = 0;
  bit done = 0;
  int unsigned seed = 32'd1357;

  bit [7:0] m_tl [2];
  bit [7:0] m_th [2];
  bit       m_ovf [2];
  bit       m_tog [2];
  bit       m_prev [2];

  always #2 clk_i = ~clk_i;

  tmr_pair u0 (.*);

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mtag(bit [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_tl[i] = 0; m_th[i] = 0; m_ovf[i] = 0; m_tog[i] = 1; m_prev[i] = 0;
    end
  endtask

  task automatic model_step();
    bit ev [2];
    bit evh;
    bit [7:0] ntl [2];
    bit [7:0] nth [2];
    evh = 0;
    for (int i = 0; i < 2; i++) begin
      bit [2:0] m;
      bit fall, inc;
      bit [12:0] c13;
      bit [15:0] c16;
      m    = mode_i[3*i +: 3];
      fall = tick_i && m_prev[i] && !cnt_pin_i[i];
      inc  = run_i[i] && (!gate_i[i] || gate_pin_i[i]) && !(i == 1 && m == 3)
             && (cnt_sel_i[i] ? fall : tick_i);
      ntl[i] = m_tl[i]; nth[i] = m_th[i]; ev[i] = 0;
      case (m)
        3'd0: if (inc) begin
          c13 = {m_th[i], m_tl[i][4:0]};
          ev[i] = (c13 == 13'h1FFF);
          c13 = c13 + 1;
          ntl[i] = {m_tl[i][7:5], c13[4:0]};
          nth[i] = c13[12:5];
        end
        3'd1: if (inc) begin
          c16 = {m_th[i], m_tl[i]};
          ev[i] = (c16 == 16'hFFFF);
          c16 = c16 + 1;
          {nth[i], ntl[i]} = c16;
        end
        3'd2: if (inc) begin
          ev[i] = (m_tl[i] == 8'hFF);
          ntl[i] = ev[i] ? m_th[i] : m_tl[i] + 1;
        end
        3'd3: begin
          if (inc) begin ev[i] = (m_tl[i] == 8'hFF); ntl[i] = m_tl[i] + 1; end
          if (i == 0 && tick_i && run_i[1]) begin
            evh = (m_th[0] == 8'hFF); nth[0] = m_th[0] + 1;
          end
        end
        3'd6: if (inc) begin ev[i] = (m_tl[i] == 8'hFF); ntl[i] = m_tl[i] + 1; end
        default: ;
      endcase
      if (wr_en_i && wr_sel_i == 2'(2*i))   ntl[i] = wr_data_i;
      if (wr_en_i && wr_sel_i == 2'(2*i+1)) nth[i] = wr_data_i;
      if (tick_i) m_prev[i] = cnt_pin_i[i];
    end
    if (mode_i[2:0] == 3) ev[1] = evh;
    for (int i = 0; i < 2; i++) begin
      m_tl[i] = ntl[i]; m_th[i] = nth[i];
      if (ev[i]) m_ovf[i] = 1; else if (ovf_clr_i[i]) m_ovf[i] = 0;
      if (!tog_en_i[i]) m_tog[i] = 1; else if (ev[i]) m_tog[i] = ~m_tog[i];
    end
  endtask

  task automatic compare_all();
    check({mtag(mode_i[2:0]), " t0 count"}, {th0_o, tl0_o}, {m_th[0], m_tl[0]});
    check({mtag(mode_i[5:3]), " t1 count"}, {th1_o, tl1_o}, {m_th[1], m_tl[1]});
    check("R9 flags", 16'(ovf_o), 16'({m_ovf[1], m_ovf[0]}));
    check("R10 toggle", 16'(tog_o), 16'({m_tog[1], m_tog[0]}));
    check("R8 pwm", 16'(pwm_o), 16'({mode_i[5:3] == 6 && m_tl[1] < m_th[1],
                                     mode_i[2:0] == 6 && m_tl[0] < m_th[0]}));
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic wr(bit [1:0] sel, bit [7:0] d);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d; tick_i = 0;
    cycle();
    wr_en_i = 0;
  endtask

  function automatic bit [2:0] pick_mode();
    int unsigned r;
    r = $urandom % 11;
    case (r)
      0, 1: return 3'd0;
      2, 3: return 3'd1;
      4, 5: return 3'd2;
      6, 7: return 3'd3;
      8, 9: return 3'd6;
      default: return 3'(4 + ($urandom % 2) * 3);
    endcase
  endfunction

  initial begin
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    check("R1 bytes", {tl0_o, th0_o}, 16'h0);
    check("R1 bytes t1", {tl1_o, th1_o}, 16'h0);
    check("R1 flags/tog/pwm", 16'({ovf_o, tog_o, pwm_o}), 16'b00_11_00);

    // R11
    wr(2'd0, 8'h12);
    check("R11 write tl0", 16'(tl0_o), 16'h12);

    // R6 with R10
    mode_i = {3'd1, 3'd2}; tog_en_i = 2'b01;
    wr(2'd1, 8'hA5); wr(2'd0, 8'hFF);
    check("R10 toggle before overflow", 16'(tog_o[0]), 16'h1);
    run_i = 2'b01; tick_i = 1; cycle();
    check("R6 reload", 16'(tl0_o), 16'hA5);
    check("R6 flag", 16'(ovf_o[0]), 16'h1);
    check("R10 toggled", 16'(tog_o[0]), 16'h0);
    run_i = 0; tick_i = 0; ovf_clr_i = 2'b01; cycle(); ovf_clr_i = 0;
    check("R9 clear", 16'(ovf_o[0]), 16'h0);

    // R4
    mode_i = {3'd1, 3'd0};
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
    run_i = 2'b01; tick_i = 1; cycle();
    check("R4 wrap tl0", 16'(tl0_o), 16'hE0);
    check("R4 wrap th0", 16'(th0_o), 16'h00);
    check("R4 flag", 16'(ovf_o[0]), 16'h1);

    // R2 gate
    mode_i = {3'd1, 3'd1}; run_i = 0;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    run_i = 2'b01; gate_i = 2'b01; gate_pin_i = 0; tick_i = 1; cycle();
    check("R2 gate closed", 16'(tl0_o), 16'h00);
    gate_pin_i = 2'b01; cycle();
    check("R2 gate open", 16'(tl0_o), 16'h01);

    // R3
    gate_i = 0; cnt_sel_i = 2'b01; cnt_pin_i = 2'b01; cycle();
    check("R3 no edge", 16'(tl0_o), 16'h01);
    cnt_pin_i = 0; cycle();
    check("R3 falling edge", 16'(tl0_o), 16'h02);
    cycle();
    check("R3 held low", 16'(tl0_o), 16'h02);
    tick_i = 0; cnt_pin_i = 2'b01; cycle(); cnt_pin_i = 0; cycle();
    check("R3 no tick", 16'(tl0_o), 16'h02);

    // random segments
    for (int s = 0; s < 24; s++) begin
      mode_i    = {pick_mode(), pick_mode()};
      tog_en_i  = 2'($urandom);
      cnt_sel_i = 2'($urandom);
      gate_i    = 2'($urandom);
      for (int c = 0; c < 160; c++) begin
        tick_i     = ($urandom % 10) < 7;
        run_i      = (($urandom % 8) != 0) ? 2'b11 : 2'($urandom);
        gate_pin_i = 2'($urandom);
        cnt_pin_i  = 2'($urandom);
        ovf_clr_i  = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
        wr_en_i    = ($urandom % 16) == 0;
        wr_sel_i   = 2'($urandom);
        case ($urandom % 3)
          0: wr_data_i = 8'hFF;
          1: wr_data_i = 8'hFE;
          default: wr_data_i = 8'($urandom);
        endcase
        cycle();
      end
    end
    wr_en_i = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule